// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This block gives a small in-order processor instruction-level control over time. It keeps a free-running 64-bit time count that advances once per clock, and a file of deadline registers. The pipeline hands it decoded timing operations through a valid/opcode interface with a register index and an offset operand. In return, the block drives a stall request, a branch-taken flag and a held exception request.

Several deadline disciplines share the same deadline registers:
- **Best effort:** wait until a deadline, and do not wait at all if it has already gone by.
- **Late detection:** after a code block finishes, branch if its deadline has expired.
- **Immediate detection:** arm an exception that fires the moment an armed deadline passes, even inside the protected code.
- **Exact finish:** stall so that a code block never completes before its deadline.

The stall and branch responses are combinational in the cycle the operation is presented. The exception is held until the pipeline acknowledges it.

Top module: `dl_timer_unit`

## Requirements
- R1: The time count is zero in the cycle after reset and increases by exactly one on every clock edge while reset is low.
- R2: Opcode 1 (set) writes deadline register `op_reg` with T + `op_offset`, where T is the time count in the cycle `op_valid` is high.
- R3: Opcode 2 (wait) raises `stall` in the same cycle while the time count is below the selected deadline. When the count equals or exceeds it, `stall` stays low.
- R4: Opcode 6 (exact finish) holds `stall` high until the time count equals the deadline, so the number of stalled cycles is the deadline minus the issue time.
- R5: Opcode 5 (branch if expired) sets `br_taken` in the same cycle exactly when the time count is equal to or past the selected deadline.
- R6: Opcode 3 (arm) makes `op_reg` armed. `exc_req` rises with `exc_idx` = that register in the cycle after the first clock edge at which the time count is at or past its deadline, that is, when the count reads deadline + 1.
- R7: Opcode 4 (disarm) clears the arm and any pending exception of `op_reg`. A deadline that later passes raises nothing.
- R8: `exc_req` stays high until a one-cycle `exc_ack`. The acknowledge clears that pending exception and disarms that register, so it does not fire again.
- R9: If several armed deadlines expire on the same edge, the lowest index is reported first, and the others remain pending for successive acknowledges.
- R10: During and right after reset, `stall`, `br_taken` and `exc_req` are low, nothing is armed, and every deadline register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A timing operation is presented this cycle |
| op_code | input | 3 | 0 none, 1 set, 2 wait, 3 arm, 4 disarm, 5 branch if expired, 6 exact finish |
| op_reg | input | 3 | Deadline register index |
| op_offset | input | 64 | Offset added to the time count by a set |
| exc_ack | input | 1 | One-cycle acknowledge of the reported exception |
| stall | output | 1 | Hold the issuing thread this cycle |
| br_taken | output | 1 | Branch-if-expired resolves taken |
| exc_req | output | 1 | Deadline-expiry exception pending |
| exc_idx | output | 3 | Register index of the reported exception |

## Verification
If a deadline register is written with a wrong value, the stall length or branch outcome is off in the same cycle that register is next queried. The bench measures both to the exact cycle against a time count it keeps itself. If the arm or pending state is corrupted, `exc_req` either rises on the wrong cycle or fails to drop or recur after an acknowledge. The bench checks this within one cycle of the expected event. A wrong priority shows up as a wrong `exc_idx` on the very first report of a simultaneous expiry.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SET    = 3'd1,
    OP_WAIT   = 3'd2,
    OP_ARM    = 3'd3,
    OP_DISARM = 3'd4,
    OP_BREXP  = 3'd5,
    OP_EXACT  = 3'd6
  } dl_op_e;
endpackage

// File: rtl/dl_timebase.sv
module dl_timebase #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + TW'(1);
  end

  assert_time_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> now == $past(now) + TW'(1));
endmodule

// File: rtl/dl_regfile.sv
module dl_regfile #(
  parameter int TW   = 64,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   wr_idx,
  input  logic [TW-1:0]   wr_val,
  input  logic [TW-1:0]   now,
  input  logic [IW-1:0]   rd_idx,
  output logic [TW-1:0]   rd_val,
  output logic [NREG-1:0] expired
);
  logic [TW-1:0] dl_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                            dl_q[g] <= '0;
      else if (we && wr_idx == IW'(g))    dl_q[g] <= wr_val;
    end
    assign expired[g] = (now >= dl_q[g]);
  end

  assign rd_val = dl_q[rd_idx];

  assert_set_loads_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> dl_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/dl_exc.sv
module dl_exc #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_en,
  input  logic            disarm_en,
  input  logic [IW-1:0]   sel_idx,
  input  logic [NREG-1:0] expired,
  input  logic            exc_ack,
  output logic            exc_req,
  output logic [IW-1:0]   exc_idx
);
  logic [NREG-1:0] arm_q, pend_q, arm_d, pend_d;

  always_comb begin
    exc_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (pend_q[i]) exc_idx = IW'(i);
  end
  assign exc_req = |pend_q;

  always_comb begin
    arm_d  = arm_q;
    pend_d = pend_q | (arm_q & expired);
    if (arm_en) arm_d[sel_idx] = 1'b1;
    if (disarm_en) begin
      arm_d[sel_idx]  = 1'b0;
      pend_d[sel_idx] = 1'b0;
    end
    if (exc_ack && exc_req) begin
      arm_d[exc_idx]  = 1'b0;
      pend_d[exc_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= '0;
      pend_q <= '0;
    end else begin
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !exc_ack && !disarm_en) |=> exc_req);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (exc_ack && exc_req) |=> !pend_q[$past(exc_idx)] && !arm_q[$past(exc_idx)]);
  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (rst)
    disarm_en |=> !pend_q[$past(sel_idx)] && !arm_q[$past(sel_idx)]);
endmodule

// File: rtl/dl_timer_unit.sv
module dl_timer_unit #(
  parameter int TW   = 64,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [IW-1:0] op_reg,
  input  logic [TW-1:0] op_offset,
  input  logic          exc_ack,
  output logic          stall,
  output logic          br_taken,
  output logic          exc_req,
  output logic [IW-1:0] exc_idx
);
  import dl_pkg::*;

  dl_op_e          op;
  logic [TW-1:0]   now, rd_val;
  logic [NREG-1:0] expired;
  logic            before_dl, is_wait;

  assign op        = dl_op_e'(op_code);
  assign before_dl = now < rd_val;
  assign is_wait   = op_valid && (op == OP_WAIT || op == OP_EXACT);
  assign stall     = is_wait && before_dl;
  assign br_taken  = op_valid && op == OP_BREXP && !before_dl;

  dl_timebase #(.TW(TW)) u_time (
    .clk(clk), .rst(rst), .now(now)
  );

  dl_regfile #(.TW(TW), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst),
    .we(op_valid && op == OP_SET), .wr_idx(op_reg), .wr_val(now + op_offset),
    .now(now), .rd_idx(op_reg), .rd_val(rd_val), .expired(expired)
  );

  dl_exc #(.NREG(NREG)) u_exc (
    .clk(clk), .rst(rst),
    .arm_en(op_valid && op == OP_ARM), .disarm_en(op_valid && op == OP_DISARM),
    .sel_idx(op_reg), .expired(expired), .exc_ack(exc_ack),
    .exc_req(exc_req), .exc_idx(exc_idx)
  );

  assert_wait_done_R3: assert property (@(posedge clk) disable iff (rst)
    (is_wait && !stall) |-> expired[op_reg]);
  assert_branch_expired_R5: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> expired[op_reg]);
endmodule

// File: tb/tb_dl_timer_unit.sv
`timescale 1ns/1ps
module tb_dl_timer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [2:0]  op_reg = 3'd0;
  logic [63:0] op_offset = '0;
  logic        exc_ack = 1'b0;
  logic        stall, br_taken, exc_req;
  logic [2:0]  exc_idx;
  logic [63:0] bt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dl_timer_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_reg(op_reg),
    .op_offset(op_offset), .exc_ack(exc_ack), .stall(stall), .br_taken(br_taken),
    .exc_req(exc_req), .exc_idx(exc_idx)
  );

  // Reference time count built from R1
  always_ff @(posedge clk) bt <= rst ? 64'd0 : bt + 64'd1;

  // {code[3], reg[3], offset[16], gap[8], expected[16]}
  localparam logic [45:0] VEC [8] = '{
    {3'd5, 3'd0, 16'd10, 8'd3, 16'd0},
    {3'd5, 3'd1, 16'd5,  8'd4, 16'd1},
    {3'd5, 3'd2, 16'd4,  8'd2, 16'd0},
    {3'd2, 3'd3, 16'd12, 8'd2, 16'd9},
    {3'd2, 3'd4, 16'd3,  8'd6, 16'd0},
    {3'd2, 3'd5, 16'd3,  8'd2, 16'd0},
    {3'd6, 3'd6, 16'd20, 8'd0, 16'd19},
    {3'd6, 3'd7, 16'd1,  8'd0, 16'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a later negedge with valid low.
  task automatic send(input logic [2:0] c, input logic [2:0] r, input logic [63:0] off,
                      output int stalls, output logic taken);
    op_valid = 1'b1; op_code = c; op_reg = r; op_offset = off;
    stalls = 0;
    #1;
    taken = br_taken;
    while (stall) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s; logic tk; logic [63:0] t0, dl_a, seen;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk(!stall && !br_taken && !exc_req, "R10 reset outputs", {stall, br_taken, exc_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: reference count equals cycles since reset; R10 deadlines are zero -> expired
    chk(bt == 64'd1, "R1 count after reset", bt, 1);
    send(3'd5, 3'd7, 0, s, tk);
    chk(tk == 1'b1, "R10 zero deadline reads expired", tk, 1);
    chk(!exc_req, "R10 nothing armed", exc_req, 0);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c; logic [2:0] r; logic [15:0] off, ex; logic [7:0] gap;
      {c, r, off, gap, ex} = VEC[i];
      send(3'd1, r, 64'(off), s, tk);
      idle(int'(gap));
      send(c, r, 0, s, tk);
      if (c == 3'd5) chk(tk == ex[0], "R5 R2 branch if expired", tk, ex);
      else if (c == 3'd2) chk(s == int'(ex), "R3 R2 wait stall cycles", s, ex);
      else chk(s == int'(ex), "R4 R2 exact finish stall cycles", s, ex);
    end

    // R4: exact finish releases exactly at the deadline
    op_valid = 1'b1; op_code = 3'd1; op_reg = 3'd2; op_offset = 64'd15;
    #1; t0 = bt; @(negedge clk);
    op_code = 3'd6; #1;
    while (stall) begin @(negedge clk); #1; end
    chk(bt == t0 + 15, "R4 release time", bt, t0 + 15);
    @(negedge clk); op_valid = 1'b0;

    // R6: immediate exception, R8 hold and ack
    op_valid = 1'b1; op_code = 3'd1; op_reg = 3'd2; op_offset = 64'd20;
    #1; dl_a = bt + 20; @(negedge clk);
    op_code = 3'd3; @(negedge clk); op_valid = 1'b0;
    seen = 0;
    for (int k = 0; k < 60 && seen == 0; k++) begin
      #1; if (exc_req) seen = bt; else @(negedge clk);
    end
    chk(seen == dl_a + 1, "R6 exception time", seen, dl_a + 1);
    chk(exc_idx == 3'd2, "R6 exception index", exc_idx, 2);
    idle(5); #1;
    chk(exc_req, "R8 held without ack", exc_req, 1);
    @(negedge clk); exc_ack = 1'b1; @(negedge clk); exc_ack = 1'b0;
    #1; chk(!exc_req, "R8 ack clears", exc_req, 0);
    idle(4); #1;
    chk(!exc_req, "R8 ack disarms", exc_req, 0);

    // R7: disarm before expiry
    @(negedge clk);
    send(3'd1, 3'd3, 64'd8, s, tk);
    send(3'd3, 3'd3, 0, s, tk);
    send(3'd4, 3'd3, 0, s, tk);
    idle(20); #1;
    chk(!exc_req, "R7 disarmed deadline raises nothing", exc_req, 0);

    // R9: simultaneous expiry
    @(negedge clk);
    send(3'd1, 3'd5, 64'd30, s, tk);
    send(3'd1, 3'd1, 64'd29, s, tk);
    send(3'd3, 3'd5, 0, s, tk);
    send(3'd3, 3'd1, 0, s, tk);
    for (int k = 0; k < 60 && !exc_req; k++) @(negedge clk);
    #1;
    chk(exc_req && exc_idx == 3'd1, "R9 lowest index first", exc_idx, 1);
    @(negedge clk); exc_ack = 1'b1; @(negedge clk); exc_ack = 1'b0;
    #1;
    chk(exc_req && exc_idx == 3'd5, "R9 second stays pending", exc_idx, 5);
    @(negedge clk); exc_ack = 1'b1; @(negedge clk); exc_ack = 1'b0;
    #1;
    chk(!exc_req, "R9 all acknowledged", exc_req, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule